// File: doc/BRIEF.md
# Three-Wire Control Port Register File

This block receives configuration commands over a write-only serial port made of a latch line, a clock line and a data line, all asynchronous to the system clock. Each command is a 16-bit word. A 2-bit address field inside the word selects one of four internal registers: two per-channel attenuation registers and two mode registers. From these registers the block drives the settings that a stereo interpolation filter datapath consumes. These are the left and right attenuation levels, soft mute, de-emphasis enable and rate, input format and word length, output word length, left/right clock polarity, filter roll-off choice and the clock-output divide.

Attenuation is applied in two steps. A write always stores a pending value. The load bit of a write makes the pending values of both channels active together. A link bit makes the right output follow the left active value. A select input lets a hardware-pin configuration bus take over the mode outputs. In that case attenuation is forced to 0 dB and the stored registers keep their contents.

Top module: `ctlport_regfile`

## Requirements
- R1: The port lines pass through two-flop synchronisers. Data is shifted in on each rising edge of the synchronised port clock, most significant bit (B15) first.
- R2: A rising edge of the latch line after exactly 16 port clock edges commits the word. The commit changes the outputs within 8 system clocks of the latch edge reaching the block.
- R3: If the latch rises after any number of port clock edges other than 16, the word is discarded and no output changes. The count restarts on every latch edge.
- R4: Bits B10:B9 of the word select the register: 00 left attenuation, 01 right attenuation, 10 mode register A, 11 mode register B. Bits B15:B11 are ignored.
- R5: An attenuation write holds an 8-bit value in B7:B0 and a load bit in B8. With load 0 the value is only stored as pending, and both attenuation outputs stay unchanged.
- R6: An attenuation write with load 1 makes the pending values of both channels active at the same time. This includes the value carried by that write.
- R7: When the link bit (mode register B, B2) is 1, att_right equals the left active value. When it is 0, each channel uses its own active value. Value FFh means 0 dB and 00h means full mute.
- R8: Mode register A fields: B0 mute-off flag (mute_on = inverse of B0), B1 de-emphasis enable, B4:B3 in_fmt[1:0], B6:B5 out_len.
- R9: Mode register B fields: B0 in_fmt[2] (two-slot serial format), B1 lr_pol, B3 slow_rolloff, B5 clkout_div2, B7:B6 deemph_rate (00 44.1 kHz, 01 reserved, 10 48 kHz, 11 32 kHz).
- R10: After reset, both attenuation outputs are FFh, every other output is 0 and the link is off.
- R11: While hw_sel is 1, the mode outputs follow hw_cfg and both attenuation outputs are FFh. The hw_cfg bit layout is [0] mute_on, [1] deemph_on, [4:2] in_fmt, [6:5] out_len, [7] lr_pol, [8] slow_rolloff, [9] clkout_div2, [11:10] deemph_rate. When hw_sel returns to 0, the stored register values come back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_latch | input | 1 | Asynchronous port latch line |
| ctl_clk | input | 1 | Asynchronous port bit clock |
| ctl_data | input | 1 | Asynchronous port data line |
| hw_sel | input | 1 | 1 selects the pin configuration bus |
| hw_cfg | input | 12 | Pin configuration bus |
| att_left | output | 8 | Left attenuation code |
| att_right | output | 8 | Right attenuation code |
| mute_on | output | 1 | Soft mute active |
| deemph_on | output | 1 | De-emphasis enabled |
| in_fmt | output | 3 | Input format and word length code |
| out_len | output | 2 | Output word length code |
| lr_pol | output | 1 | Left/right clock polarity |
| slow_rolloff | output | 1 | Slow roll-off selected |
| clkout_div2 | output | 1 | Clock output divided by two |
| deemph_rate | output | 2 | De-emphasis sample-rate code |

## Verification
The bench builds the block with its defaults: 16-bit words, 8-bit attenuation and two synchroniser stages. These values make the real address field position and the load bit at B8 reachable. They also cover both attenuation extremes, 00h and FFh, and the reserved upper bits that have to fall away. With a 16-bit word, words of 15 and 17 bits land on both sides of the commit count. This shows that a short word and an overlong word are both discarded.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;

  typedef enum logic [1:0] {
    SEL_ATT_L  = 2'b00,
    SEL_ATT_R  = 2'b01,
    SEL_MODE_A = 2'b10,
    SEL_MODE_B = 2'b11
  } reg_sel_e;

  // bit 0 is mute, matching the pin bus layout
  typedef struct packed {
    logic [1:0] rate;
    logic       div2;
    logic       slow;
    logic       lr_pol;
    logic [1:0] out_len;
    logic [2:0] in_fmt;
    logic       deemph;
    logic       mute;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d_async,
  output logic [LINES-1:0] q_sync
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async[g]};
    end
    assign q_sync[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/ctl_shifter.sv
module ctl_shifter #(
  parameter int WORD_W = 16,
  parameter int KEEP_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              latch_s,
  input  logic              data_s,
  output logic [KEEP_W-1:0] word_o,
  output logic              commit_o
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);

  logic              sclk_d, latch_d;
  logic [CNT_W-1:0]  cnt;
  logic [KEEP_W-1:0] shreg;
  logic              sclk_rise, latch_rise, latch_fall;

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign latch_rise = latch_s & ~latch_d;
  assign latch_fall = ~latch_s & latch_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      latch_d  <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      word_o   <= '0;
      commit_o <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      latch_d  <= latch_s;
      commit_o <= 1'b0;
      if (latch_rise) begin
        if (cnt == FULL) begin
          commit_o <= 1'b1;
          word_o   <= shreg;
        end
        cnt <= '0;
      end else if (latch_fall) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        // upper reserved bits shift out of the kept window
        shreg <= {shreg[KEEP_W-2:0], data_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  assert_commit_on_latch_R2: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(latch_s && !latch_d));

  assert_discard_wrong_count_R3: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> ($past(cnt) == FULL));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctlport_pkg::*;
#(
  parameter int ATT_W  = 8,
  parameter int KEEP_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [KEEP_W-1:0] word,
  output logic [ATT_W-1:0]  act_l,
  output logic [ATT_W-1:0]  act_r,
  output logic              link,
  output cfg_t              cfg
);

  localparam int LOAD_BIT = ATT_W;
  localparam int ADDR_LSB = ATT_W + 1;

  reg_sel_e         sel;
  logic [ATT_W-1:0] val, pend_l, pend_r;
  logic             ld;
  logic             mut_n, dem, i2s, lrp, sro, cko;
  logic [1:0]       iw, ow, sf;

  assign sel = reg_sel_e'(word[ADDR_LSB+1:ADDR_LSB]);
  assign val = word[ATT_W-1:0];
  assign ld  = word[LOAD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_l <= '1;
      pend_r <= '1;
      act_l  <= '1;
      act_r  <= '1;
      mut_n  <= 1'b1;
      dem    <= 1'b0;
      iw     <= 2'b00;
      ow     <= 2'b00;
      i2s    <= 1'b0;
      lrp    <= 1'b0;
      link   <= 1'b0;
      sro    <= 1'b0;
      cko    <= 1'b0;
      sf     <= 2'b00;
    end else if (commit) begin
      case (sel)
        SEL_ATT_L: begin
          pend_l <= val;
          if (ld) begin
            act_l <= val;
            act_r <= pend_r;
          end
        end
        SEL_ATT_R: begin
          pend_r <= val;
          if (ld) begin
            act_r <= val;
            act_l <= pend_l;
          end
        end
        SEL_MODE_A: begin
          mut_n <= word[0];
          dem   <= word[1];
          iw    <= word[4:3];
          ow    <= word[6:5];
        end
        default: begin
          i2s  <= word[0];
          lrp  <= word[1];
          link <= word[2];
          sro  <= word[3];
          cko  <= word[5];
          sf   <= word[7:6];
        end
      endcase
    end
  end

  always_comb begin
    cfg.mute    = ~mut_n;
    cfg.deemph  = dem;
    cfg.in_fmt  = {i2s, iw};
    cfg.out_len = ow;
    cfg.lr_pol  = lrp;
    cfg.slow    = sro;
    cfg.div2    = cko;
    cfg.rate    = sf;
  end

  assert_noload_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && !ld && (sel == SEL_ATT_L || sel == SEL_ATT_R))
      |=> ($stable(act_l) && $stable(act_r)));

  assert_mode_only_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(cfg) && $stable(link)));

endmodule

// File: rtl/ctlport_regfile.sv
module ctlport_regfile
  import ctlport_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ATT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_latch,
  input  logic             ctl_clk,
  input  logic             ctl_data,
  input  logic             hw_sel,
  input  logic [11:0]      hw_cfg,
  output logic [ATT_W-1:0] att_left,
  output logic [ATT_W-1:0] att_right,
  output logic             mute_on,
  output logic             deemph_on,
  output logic [2:0]       in_fmt,
  output logic [1:0]       out_len,
  output logic             lr_pol,
  output logic             slow_rolloff,
  output logic             clkout_div2,
  output logic [1:0]       deemph_rate
);

  localparam int KEEP_W = ATT_W + 3;

  logic [2:0]        sync_q;
  logic [KEEP_W-1:0] word;
  logic              commit;
  logic [ATT_W-1:0]  act_l, act_r;
  logic              link;
  cfg_t              reg_cfg, out_cfg;

  ctl_sync #(.STAGES(SYNC_STAGES), .LINES(3)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({ctl_data, ctl_clk, ctl_latch}),
    .q_sync  (sync_q)
  );

  ctl_shifter #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sync_q[1]),
    .latch_s  (sync_q[0]),
    .data_s   (sync_q[2]),
    .word_o   (word),
    .commit_o (commit)
  );

  ctl_regbank #(.ATT_W(ATT_W), .KEEP_W(KEEP_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .word   (word),
    .act_l  (act_l),
    .act_r  (act_r),
    .link   (link),
    .cfg    (reg_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      att_left  <= '1;
      att_right <= '1;
      out_cfg   <= '0;
    end else if (hw_sel) begin
      att_left  <= '1;
      att_right <= '1;
      out_cfg   <= cfg_t'(hw_cfg);
    end else begin
      att_left  <= act_l;
      att_right <= link ? act_l : act_r;
      out_cfg   <= reg_cfg;
    end
  end

  assign mute_on      = out_cfg.mute;
  assign deemph_on    = out_cfg.deemph;
  assign in_fmt       = out_cfg.in_fmt;
  assign out_len      = out_cfg.out_len;
  assign lr_pol       = out_cfg.lr_pol;
  assign slow_rolloff = out_cfg.slow;
  assign clkout_div2  = out_cfg.div2;
  assign deemph_rate  = out_cfg.rate;

  assert_bypass_att_R11: assert property (@(posedge clk) disable iff (rst)
    $past(hw_sel) |-> (att_left == '1 && att_right == '1));

  assert_link_follows_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(link) && !$past(hw_sel)) |-> (att_right == att_left));

endmodule

// File: tb/ctlport_regfile_tb.sv
module ctlport_regfile_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 4;
  localparam int SETTLE     = 12;
  localparam int WATCHDOG   = 50000;
  localparam int NVEC       = 9;

  // {command word, expected att_left, expected att_right, expected cfg bus}
  localparam logic [43:0] VEC [NVEC] = '{
    {16'h0040, 8'hFF, 8'hFF, 12'h000},  // R5 pending only
    {16'h0380, 8'h40, 8'h80, 12'h000},  // R6 load moves both
    {16'h0472, 8'h40, 8'h80, 12'h06B},  // R8 mode A
    {16'h06AF, 8'h40, 8'h40, 12'hBFB},  // R9 mode B, R7 link on
    {16'hF900, 8'h00, 8'h00, 12'hBFB},  // R4 reserved bits, R7 full mute linked
    {16'h06AB, 8'h00, 8'h80, 12'hBFB},  // R7 link off
    {16'h0211, 8'h00, 8'h80, 12'hBFB},  // R5 right pending only
    {16'h0401, 8'h00, 8'h80, 12'hB90},  // R8 mute off
    {16'hF9FE & 16'h07FF, 8'hFE, 8'h11, 12'hB90}  // R6 left load pulls right pending
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_latch = 1'b1;
  logic        ctl_clk = 1'b0;
  logic        ctl_data = 1'b0;
  logic        hw_sel = 1'b0;
  logic [11:0] hw_cfg = '0;
  logic [7:0]  att_left, att_right;
  logic        mute_on, deemph_on, lr_pol, slow_rolloff, clkout_div2;
  logic [2:0]  in_fmt;
  logic [1:0]  out_len, deemph_rate;
  logic [11:0] cfg_seen;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlport_regfile u_dut (
    .clk          (clk),
    .rst          (rst),
    .ctl_latch    (ctl_latch),
    .ctl_clk      (ctl_clk),
    .ctl_data     (ctl_data),
    .hw_sel       (hw_sel),
    .hw_cfg       (hw_cfg),
    .att_left     (att_left),
    .att_right    (att_right),
    .mute_on      (mute_on),
    .deemph_on    (deemph_on),
    .in_fmt       (in_fmt),
    .out_len      (out_len),
    .lr_pol       (lr_pol),
    .slow_rolloff (slow_rolloff),
    .clkout_div2  (clkout_div2),
    .deemph_rate  (deemph_rate)
  );

  assign cfg_seen = {deemph_rate, clkout_div2, slow_rolloff, lr_pol,
                     out_len, in_fmt, deemph_on, mute_on};

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [7:0] el,
                           input logic [7:0] er, input logic [11:0] ec);
    check(req, "att_left",  {8'h00, att_left},  {8'h00, el});
    check(req, "att_right", {8'h00, att_right}, {8'h00, er});
    check(req, "cfg",       {4'h0, cfg_seen},   {4'h0, ec});
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends nbits bits, MSB first (R1); extra bits wrap round the word
  task automatic send_word(input logic [15:0] w, input int nbits);
    ctl_latch = 1'b0;
    wait_clks(PHASE);
    for (int i = 0; i < nbits; i++) begin
      ctl_data = w[15 - (i % 16)];
      wait_clks(PHASE);
      ctl_clk = 1'b1;
      wait_clks(PHASE);
      ctl_clk = 1'b0;
    end
    wait_clks(PHASE);
    ctl_latch = 1'b1;
    wait_clks(SETTLE);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait_clks(WATCHDOG);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clks(3);
    rst = 1'b0;
    wait_clks(SETTLE);
    check_all("R10 reset", 8'hFF, 8'hFF, 12'h000);

    for (int i = 0; i < NVEC; i++) begin
      send_word(VEC[i][43:28], 16);
      check_all($sformatf("R1/R2 vector %0d", i),
                VEC[i][27:20], VEC[i][19:12], VEC[i][11:0]);
    end

    // R3 short and long words are discarded
    send_word(16'h0472, 15);
    check_all("R3 short word", 8'hFE, 8'h11, 12'hB90);
    send_word(16'h0380, 17);
    check_all("R3 long word", 8'hFE, 8'h11, 12'hB90);

    // R11 pin bus bypass and return
    hw_cfg = 12'h5A5;
    hw_sel = 1'b1;
    wait_clks(2);
    check_all("R11 bypass", 8'hFF, 8'hFF, 12'h5A5);
    hw_sel = 1'b0;
    wait_clks(2);
    check_all("R11 restore", 8'hFE, 8'h11, 12'hB90);

    // R10 reset in the middle of operation
    rst = 1'b1;
    wait_clks(2);
    rst = 1'b0;
    wait_clks(2);
    check_all("R10 mid reset", 8'hFF, 8'hFF, 12'h000);

    finish_run();
  end

endmodule